// File: doc/BRIEF.md
# PCI Interrupt Line to ISA IRQ Router

This block steers four level-sensitive PCI interrupt lines onto sixteen ISA interrupt request outputs. Each PCI line owns one byte-wide steering register. The low four bits of that register name the target ISA IRQ. A value of sixteen or above turns the line off. Any number of PCI lines may point at the same IRQ. That IRQ output is then the wired-OR of every line steered to it.

The block keeps a registered level matrix with one cell per (IRQ, PCI line) pair. Every cell is rebuilt on every clock from the current line levels and the current steering. A steering change therefore moves an interrupt that is already asserted over to its new IRQ without further action. The block also publishes, for each PCI line, an enable flag and the IRQ it currently drives.

Software reaches the steering registers through a dword-addressed configuration port with byte enables. The four registers share one dword, configuration byte offsets 0x60 to 0x63, so the dword address is 0x18.

Top module: `irqrt_router`

## Requirements
- R1: The steering registers sit in dword address 0x18. Byte lane k (bits 8k+7..8k) holds the register of PCI line k, with line A in lane 0 and line D in lane 3.
- R2: A steering value of 16 or greater, whatever its low four bits, disables that line. It then drives no ISA IRQ.
- R3: Reset is synchronous and active high. After reset every steering register reads 0x80, every IRQ output is 0 and every route enable is 0, whatever the line inputs are.
- R4: IRQ output i is 1 when at least one enabled line steered to i is asserted. Several lines steered to one IRQ combine as an OR.
- R5: Consider a steering write sampled at clock edge N. The register takes the new value at edge N. The IRQ outputs follow the new steering from edge N+1. An asserted line then appears on its new IRQ and leaves its old one.
- R6: For each line k, route_en[k] is 1 exactly when its register value is below 16. route_irq[4k+3:4k] then holds the low four bits of the register; otherwise it is 0. Both change at the edge that writes the register.
- R7: A write updates only the byte lanes whose cfg_be bit is 1. The other registers keep their values.
- R8: A write to any dword address other than 0x18 changes no register and no output. A read of any other address returns 0.
- R9: A read of address 0x18 returns all four stored bytes unchanged, upper bits included, with no clock delay.
- R10: The IRQ outputs reflect the line inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| pirq | input | 4 | PCI interrupt line levels, line A in bit 0 |
| irq_out | output | 16 | ISA IRQ outputs |
| route_en | output | 4 | Per-line steering enable |
| route_irq | output | 16 | Per-line target IRQ, 4 bits per line |

## Verification
Two things can land in the same cycle: a steering write, and a change on the line inputs. To provoke this, the bench writes line A's register in the same cycle that line B rises. On the first edge, the outputs must show B at its IRQ and A still at its old IRQ. On the next edge, A must have moved to its new IRQ. Each of those two cycles is compared against a value computed in the bench from the requirements.

// File: rtl/irqrt_pkg.sv
package irqrt_pkg;
    localparam int NUM_PIRQ    = 4;
    localparam int NUM_IRQ     = 16;
    localparam int IRQ_W       = $clog2(NUM_IRQ);
    localparam int BYTE_W      = 8;
    localparam int DATA_W      = NUM_PIRQ * BYTE_W;
    localparam logic [BYTE_W-1:0] ROUTE_RESET = 8'h80;

    typedef struct packed {
        logic             en;
        logic [IRQ_W-1:0] irq;
    } route_t;

    typedef logic [NUM_PIRQ-1:0][BYTE_W-1:0] route_bytes_t;

    function automatic route_t decode_route(input logic [BYTE_W-1:0] b);
        route_t r;
        r.en  = (b < BYTE_W'(NUM_IRQ));
        r.irq = r.en ? b[IRQ_W-1:0] : '0;
        return r;
    endfunction
endpackage

// File: rtl/irqrt_cfg.sv
module irqrt_cfg
    import irqrt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DWORD = 6'h18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PIRQ-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output route_bytes_t        route_q
);
    logic hit;
    assign hit = (addr == ROUTE_DWORD);

    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                route_q[k] <= ROUTE_RESET;
            else if (wr && hit && be[k])
                route_q[k] <= wdata[k*BYTE_W +: BYTE_W];
        end
    end

    assign rdata = hit ? route_q : '0;

    // R8: foreign addresses never touch the steering registers
    p_foreign_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && !hit) |=> $stable(route_q));

    // R7: a write with no lane enabled leaves the registers as they were
    p_no_lane_no_change_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && be == '0) |=> $stable(route_q));

    // R3: the first cycle out of reset shows the reset value in every lane
    p_reset_value_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_q == {NUM_PIRQ{ROUTE_RESET}}));
endmodule

// File: rtl/irqrt_decode.sv
module irqrt_decode
    import irqrt_pkg::*;
(
    input  route_bytes_t                  route_q,
    output route_t [NUM_PIRQ-1:0]         status
);
    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_dec
        assign status[k] = decode_route(route_q[k]);
    end
endmodule

// File: rtl/irqrt_matrix.sv
module irqrt_matrix
    import irqrt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PIRQ-1:0]   pirq,
    input  route_t [NUM_PIRQ-1:0] status,
    output logic [NUM_IRQ-1:0]    irq_out
);
    logic [NUM_IRQ-1:0][NUM_PIRQ-1:0] lvl_q;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam logic [IRQ_W-1:0] IDX = IRQ_W'(i);
        for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst)
                    lvl_q[i][k] <= 1'b0;
                else
                    lvl_q[i][k] <= pirq[k] & status[k].en & (status[k].irq == IDX);
            end
        end
        assign irq_out[i] = |lvl_q[i];
    end

    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_col
        logic [NUM_IRQ-1:0] col;
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
            assign col[i] = lvl_q[i][k];
        end

        // R2: a disabled line leaves its whole column empty
        p_disabled_col_empty_r2: assert property (@(posedge clk) disable iff (rst)
            !status[k].en |=> (col == '0));

        // R4: a line lands on at most one IRQ
        p_col_onehot_r4: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
    end
endmodule

// File: rtl/irqrt_router.sv
module irqrt_router
    import irqrt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DWORD = 6'h18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_wr,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [NUM_PIRQ-1:0]       cfg_be,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output logic [DATA_W-1:0]         cfg_rdata,
    input  logic [NUM_PIRQ-1:0]       pirq,
    output logic [NUM_IRQ-1:0]        irq_out,
    output logic [NUM_PIRQ-1:0]       route_en,
    output logic [NUM_PIRQ*IRQ_W-1:0] route_irq
);
    route_bytes_t          route_q;
    route_t [NUM_PIRQ-1:0] status;

    irqrt_cfg #(.ADDR_W(ADDR_W), .ROUTE_DWORD(ROUTE_DWORD)) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .route_q(route_q)
    );

    irqrt_decode u_dec (.route_q(route_q), .status(status));

    irqrt_matrix u_mtx (
        .clk(clk), .rst(rst), .pirq(pirq), .status(status), .irq_out(irq_out)
    );

    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_stat
        assign route_en[k]                 = status[k].en;
        assign route_irq[k*IRQ_W +: IRQ_W] = status[k].irq;

        // R4, R6: an enabled, asserted line shows up next cycle on its published IRQ
        p_enabled_reaches_irq_r6: assert property (@(posedge clk) disable iff (rst)
            (route_en[k] && pirq[k]) |=> irq_out[$past(route_irq[k*IRQ_W +: IRQ_W])]);
    end

    // R10: no IRQ without an asserted line one cycle earlier, and never more IRQs than lines
    p_irq_needs_line_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ($past(pirq) != '0));

    p_wired_or_count_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= $countones($past(pirq)));
endmodule

// File: tb/irqrt_router_test.sv
module irqrt_router_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [3:0]  pirq;
    logic [15:0] irq_out;
    logic [3:0]  route_en;
    logic [15:0] route_irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] route_m [4];

    always #4 clk = ~clk;

    irqrt_router uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pirq(pirq), .irq_out(irq_out),
        .route_en(route_en), .route_irq(route_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_irq(input logic [3:0] pat);
        logic [15:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (pat[k] && route_m[k] < 8'd16) r[route_m[k][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        if (a == 6'h18)
            for (int k = 0; k < 4; k++) if (be[k]) route_m[k] = d[k*8 +: 8];
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = 6'h18;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic chk_status(input string req);
        logic [3:0]  e_en;
        logic [15:0] e_irq;
        for (int k = 0; k < 4; k++) begin
            e_en[k] = route_m[k] < 8'd16;
            e_irq[k*4 +: 4] = e_en[k] ? route_m[k][3:0] : 4'd0;
        end
        chk(route_en == e_en && route_irq == e_irq, req, {route_en, route_irq}, {e_en, e_irq});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog timeout");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 6'h18; cfg_be = '0; cfg_wdata = '0; pirq = 4'hF;
        for (int k = 0; k < 4; k++) route_m[k] = 8'h80;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        chk(cfg_rdata == 32'h80808080, "R3 reset route", cfg_rdata, 32'h80808080);
        chk(irq_out == 16'h0, "R3 reset irq", {16'h0, irq_out}, 32'h0);
        chk(route_en == 4'h0, "R3 reset route_en", {28'h0, route_en}, 32'h0);

        // R1 R2 R4 R6: each line alone onto every IRQ, every line pattern
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 16; v++) begin
                logic [31:0] d = 32'h80808080;
                d[k*8 +: 8] = 8'(v);
                wr(6'h18, 4'hF, d);
                chk(cfg_rdata == d, "R1 readback", cfg_rdata, d);
                chk_status("R6 status");
                for (int p = 0; p < 16; p++) begin
                    pirq = 4'(p);
                    settle();
                    chk(irq_out == exp_irq(4'(p)), "R4 single route", {16'h0, irq_out}, {16'h0, exp_irq(4'(p))});
                end
            end
        end

        // R4: all lines shared on IRQ 5, then pairs shared
        wr(6'h18, 4'hF, 32'h05050505);
        for (int p = 0; p < 16; p++) begin
            pirq = 4'(p); settle();
            chk(irq_out == exp_irq(4'(p)), "R4 shared irq", {16'h0, irq_out}, {16'h0, exp_irq(4'(p))});
        end
        wr(6'h18, 4'hF, 32'h0E0E0101);
        for (int p = 0; p < 16; p++) begin
            pirq = 4'(p); settle();
            chk(irq_out == exp_irq(4'(p)), "R4 pair share", {16'h0, irq_out}, {16'h0, exp_irq(4'(p))});
        end

        // R2 R9: disabled values with various low bits, upper bits kept on read
        wr(6'h18, 4'hF, 32'h10FF8F9A);
        chk(cfg_rdata == 32'h10FF8F9A, "R9 raw readback", cfg_rdata, 32'h10FF8F9A);
        chk_status("R2 disabled status");
        pirq = 4'hF; settle();
        chk(irq_out == 16'h0, "R2 disabled no drive", {16'h0, irq_out}, 32'h0);

        // R7 byte enables
        wr(6'h18, 4'hF, 32'h80800C03);
        wr(6'h18, 4'b0101, 32'h0A0B0C0D);
        chk(cfg_rdata == 32'h800B0C0D, "R7 byte enables", cfg_rdata, 32'h800B0C0D);
        chk_status("R7 status");

        // R8 foreign address
        wr(6'h18, 4'hF, 32'h80800C03);
        pirq = 4'h3; settle();
        wr(6'h19, 4'hF, 32'h00000000);
        settle();
        chk(cfg_rdata == 32'h80800C03, "R8 regs kept", cfg_rdata, 32'h80800C03);
        chk(irq_out == 16'h1008, "R8 irq kept", {16'h0, irq_out}, 32'h1008);
        cfg_addr = 6'h19; #1;
        chk(cfg_rdata == 32'h0, "R8 foreign read", cfg_rdata, 32'h0);
        cfg_addr = 6'h18;

        // R5 R10: route write and line change in the same cycle
        pirq = 4'h1; settle();
        chk(irq_out == 16'h0008, "R10 setup", {16'h0, irq_out}, 32'h0008);
        cfg_wr = 1'b1; cfg_be = 4'b0001; cfg_wdata = 32'h00000009; pirq = 4'h3;
        @(negedge clk);
        cfg_wr = 1'b0; route_m[0] = 8'h09;
        chk(irq_out == 16'h1008, "R10 line seen old route", {16'h0, irq_out}, 32'h1008);
        chk(route_en[0] && route_irq[3:0] == 4'd9, "R6 status on write edge", {16'h0, route_irq}, 32'h9);
        @(negedge clk);
        chk(irq_out == 16'h1200, "R5 moved to new irq", {16'h0, irq_out}, 32'h1200);
        pirq = 4'h0;
        @(negedge clk);
        chk(irq_out == 16'h0, "R10 deassert next edge", {16'h0, irq_out}, 32'h0);

        // R3 reset again with lines asserted
        pirq = 4'hF; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) route_m[k] = 8'h80;
        @(negedge clk);
        chk(cfg_rdata == 32'h80808080 && irq_out == 16'h0, "R3 rereset", {cfg_rdata[15:0], irq_out}, 32'h80800000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule